// File: doc/BRIEF.md
# Edge-Latched Interrupt Request Arbiter

This block is the interrupt front end of a small 8-bit accumulator processor. It watches a non-maskable request line, a set of level-sensitive maskable request lines and a set-overflow pin. At each instruction boundary it decides whether the opcode just fetched goes through or is replaced by the break opcode, which starts the interrupt entry sequence.

The non-maskable line is edge sensitive. An inactive-to-active transition loads a pending latch. The latch stays set after the line drops and is cleared only when the entry sequencer acknowledges that the non-maskable vector was taken. Holding the line active produces one request, not a stream of them.

The maskable lines are combined by OR and are honoured only while the processor's interrupt-disable flag is clear. An inhibit input blocks every kind of request at the boundary. A wake output serves the wait-for-interrupt instruction and ignores the disable flag. A separate pin raises a one-cycle pulse that sets the overflow flag, on its rising edge only.

Top module: `irq_front`

## Requirements
- R1: A low-to-high transition of `nmi_line`, seen at a rising clock edge, sets `nmi_pend` at that edge. A pulse one cycle wide is enough.
- R2: While `nmi_line` stays high, no further requests follow. After an acknowledge clears `nmi_pend`, it stays clear for as long as the line remains high.
- R3: `nmi_pend` stays set after `nmi_line` goes low. It clears at the clock edge where `nmi_ack` is high.
- R4: When a new `nmi_line` edge and `nmi_ack` coincide at the same clock edge, `nmi_pend` ends up set.
- R5: The `irq_lines` inputs are ORed. At a boundary (`boundary`=1) with `inhibit`=0, any high line is honoured only if `int_disable`=0.
- R6: When `inhibit`=1, no request is honoured, whether NMI or maskable, and `op_out` equals `fetched_op`.
- R7: When a request is honoured, `op_out` is 8'h00 in the same cycle. Otherwise `op_out` equals `fetched_op`.
- R8: `taken` loads the honour decision at every clock edge where `boundary`=1, and holds its value when `boundary`=0.
- R9: A low-to-high transition of `ovf_pin` makes `set_v` high for exactly the one cycle after that clock edge. A held level gives no further pulses.
- R10: `wake` is high whenever `nmi_pend` is set or any `irq_lines` bit is high. It does not depend on `int_disable` or `inhibit`.
- R11: Reset (`rst_n`=0) clears `nmi_pend`, `taken`, `set_v` and the sampled line states. An `nmi_line` held high through reset therefore counts as an edge at the first clock after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_line | input | 1 | Non-maskable request, active high |
| irq_lines | input | NUM_IRQ | Maskable requests, level sensitive, active high |
| ovf_pin | input | 1 | Set-overflow pin, active high |
| int_disable | input | 1 | Interrupt-disable flag from the status register |
| inhibit | input | 1 | Blocks all requests at the boundary |
| boundary | input | 1 | Opcode-prefetch boundary strobe |
| fetched_op | input | OP_W | Opcode read from memory |
| nmi_ack | input | 1 | Entry sequencer has taken the non-maskable vector |
| op_out | output | OP_W | Opcode passed to the instruction register |
| taken | output | 1 | The last boundary forced a break |
| nmi_pend | output | 1 | Non-maskable request pending |
| set_v | output | 1 | One-cycle pulse that sets the overflow flag |
| wake | output | 1 | Wake condition for wait-for-interrupt |

## Verification
The bench builds the block with its defaults: two maskable lines, an 8-bit opcode and a break opcode of 8'h00. With these values every combination of one line versus the other and masked versus unmasked can be reached, and the substituted opcode can be told apart from a nonzero fetched value. The directed scenarios cover the cases that matter for edge latching: a one-cycle pulse, a line held through an acknowledge, a line held through reset, and an edge that coincides with an acknowledge.

// File: rtl/irq_front.sv
module irq_front #(
  parameter int          NUM_IRQ = 2,
  parameter int          OP_W    = 8,
  parameter logic [7:0]  BRK_OP  = 8'h00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               nmi_line,
  input  logic [NUM_IRQ-1:0] irq_lines,
  input  logic               ovf_pin,
  input  logic               int_disable,
  input  logic               inhibit,
  input  logic               boundary,
  input  logic [OP_W-1:0]    fetched_op,
  input  logic               nmi_ack,
  output logic [OP_W-1:0]    op_out,
  output logic               taken,
  output logic               nmi_pend,
  output logic               set_v,
  output logic               wake
);
  localparam logic [OP_W-1:0] BRK = OP_W'(BRK_OP);

  logic nmi_q, ovf_q;
  logic nmi_edge, ovf_edge, any_irq, honour;

  assign nmi_edge = nmi_line & ~nmi_q;
  assign ovf_edge = ovf_pin & ~ovf_q;
  assign any_irq  = |irq_lines;
  assign honour   = boundary & ~inhibit & (nmi_pend | (any_irq & ~int_disable));
  assign op_out   = honour ? BRK : fetched_op;
  assign wake     = nmi_pend | any_irq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q    <= 1'b0;
      ovf_q    <= 1'b0;
      nmi_pend <= 1'b0;
      taken    <= 1'b0;
      set_v    <= 1'b0;
    end else begin
      nmi_q    <= nmi_line;
      ovf_q    <= ovf_pin;
      nmi_pend <= nmi_edge | (nmi_pend & ~nmi_ack);
      if (boundary) taken <= honour;
      set_v    <= ovf_edge;
    end
  end

  assert_nmi_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_line && !nmi_q) |=> nmi_pend);
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_pend) |-> $past(nmi_line && !nmi_q));
  assert_pend_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend && !nmi_ack) |=> nmi_pend);
  assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_ack && !(nmi_line && !nmi_q)) |=> !nmi_pend);
  assert_inhibit_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> op_out == fetched_op);
  assert_nmi_break_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !inhibit && nmi_pend) |-> op_out == BRK);
  assert_taken_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(taken));
  assert_setv_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_v |=> !set_v);
  assert_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend || irq_lines != '0) |-> wake);
endmodule

// File: tb/tb_irq_front.sv
`timescale 1ns/1ps
module tb_irq_front;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       nmi_line, ovf_pin, int_disable, inhibit, boundary, nmi_ack;
  logic [1:0] irq_lines;
  logic [7:0] fetched_op, op_out;
  logic       taken, nmi_pend, set_v, wake;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  irq_front dut (
    .clk(clk), .rst_n(rst_n), .nmi_line(nmi_line), .irq_lines(irq_lines),
    .ovf_pin(ovf_pin), .int_disable(int_disable), .inhibit(inhibit),
    .boundary(boundary), .fetched_op(fetched_op), .nmi_ack(nmi_ack),
    .op_out(op_out), .taken(taken), .nmi_pend(nmi_pend), .set_v(set_v), .wake(wake)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic idle();
    nmi_line = 0; ovf_pin = 0; int_disable = 0; inhibit = 0;
    boundary = 0; nmi_ack = 0; irq_lines = 2'b00; fetched_op = 8'hA9;
  endtask

  task automatic clear_pend();
    nmi_ack = 1; step(); nmi_ack = 0;
  endtask

  task automatic t_reset();
    idle(); nmi_line = 1; rst_n = 0; step(); step();
    check("R11 pend after reset", nmi_pend, 0);
    check("R11 taken after reset", taken, 0);
    check("R11 set_v after reset", set_v, 0);
    rst_n = 1; step();
    check("R11 held line counts as edge", nmi_pend, 1);
    nmi_line = 0; clear_pend(); step();
    check("R11 cleared", nmi_pend, 0);
  endtask

  task automatic t_pulse();
    nmi_line = 1; step(); nmi_line = 0;
    check("R1 one-cycle pulse latched", nmi_pend, 1);
    step(); step();
    check("R3 pend persists after release", nmi_pend, 1);
    nmi_ack = 1; #1;
    check("R3 pend still set during ack cycle", nmi_pend, 1);
    step(); nmi_ack = 0;
    check("R3 ack clears pend", nmi_pend, 0);
  endtask

  task automatic t_held();
    nmi_line = 1; step();
    check("R1 edge latched", nmi_pend, 1);
    clear_pend();
    check("R2 cleared while held", nmi_pend, 0);
    step(); step(); step();
    check("R2 held line no retrigger", nmi_pend, 0);
    nmi_line = 0; step();
    nmi_line = 1; step();
    check("R1 new edge after release", nmi_pend, 1);
    nmi_line = 0; clear_pend();
  endtask

  task automatic t_collide();
    nmi_line = 1; step(); nmi_line = 0; step();
    check("R4 pend before collide", nmi_pend, 1);
    nmi_line = 1; nmi_ack = 1; step(); nmi_ack = 0;
    check("R4 edge wins over ack", nmi_pend, 1);
    nmi_line = 0; clear_pend();
  endtask

  task automatic t_maskable();
    irq_lines = 2'b10; boundary = 1; #1;
    check("R5 line1 unmasked honoured", op_out, 8'h00);
    check("R7 break opcode same cycle", op_out, 8'h00);
    step();
    check("R8 taken set", taken, 1);
    boundary = 0; step(); step();
    check("R8 taken holds off boundary", taken, 1);
    int_disable = 1; irq_lines = 2'b01; #1;
    check("R10 wake ignores disable", wake, 1);
    boundary = 1; #1;
    check("R5 masked passes fetched", op_out, 8'hA9);
    step();
    check("R8 taken cleared by unhonoured boundary", taken, 0);
    boundary = 0; irq_lines = 2'b00; int_disable = 0; #1;
    check("R10 wake low when idle", wake, 0);
    fetched_op = 8'h4C; boundary = 1; #1;
    check("R7 no request passes fetched", op_out, 8'h4C);
    step(); boundary = 0;
  endtask

  task automatic t_inhibit();
    nmi_line = 1; step(); nmi_line = 0;
    irq_lines = 2'b11; inhibit = 1; boundary = 1; #1;
    check("R6 inhibit blocks", op_out, 8'h4C);
    check("R10 wake ignores inhibit", wake, 1);
    step();
    check("R6 taken stays clear", taken, 0);
    irq_lines = 2'b00; inhibit = 0; int_disable = 1; #1;
    check("R7 NMI ignores disable", op_out, 8'h00);
    step(); boundary = 0; int_disable = 0;
    check("R8 taken by NMI", taken, 1);
    clear_pend();
  endtask

  task automatic t_overflow();
    ovf_pin = 1; step();
    check("R9 pulse after edge", set_v, 1);
    step();
    check("R9 pulse one cycle", set_v, 0);
    step(); step();
    check("R9 held level no pulse", set_v, 0);
    ovf_pin = 0; step(); ovf_pin = 1; step();
    check("R9 second edge pulses", set_v, 1);
    ovf_pin = 0; step();
  endtask

  initial begin
    t_reset();
    t_pulse();
    t_held();
    t_collide();
    t_maskable();
    t_inhibit();
    t_overflow();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule